// File: doc/BRIEF.md
# Command/Response FIFO Register Interface

This block sits between a host register port and a security-processor core. The host reaches four registers by address: a locality/access register, a status register, a byte-wide data FIFO and a read-only identity word. Behind them a five-state controller (idle, ready, receiving, executing, done) owns one byte buffer. That buffer holds the incoming command and, after execution, the outgoing response.

A normal exchange runs as follows. The host writes the command-ready status bit and then streams command bytes into the FIFO register, one per write. The block watches the big-endian size field in header bytes 2 to 5 and keeps an "expect more" status bit set until the full command has arrived. A go write then raises a one-cycle execute request to the core. The core writes its response bytes by index into the same buffer and commits a length. The host polls for data-available and drains the response through FIFO reads. A command-ready write, or giving up the locality, aborts the exchange and empties the buffer.

Top module: `tpm_fifo_ctrl`

## Requirements
- R1: After reset the controller is idle. Reads return one cycle after the request. The identity register (0xF00) returns the IDENT parameter with count 4. The access register (0x000) returns 0x80 (bit 7 register-valid) with count 1. The status register (0x018) returns 0x04004080 with count 4: bits 27:26 family code 01, bits 23:8 burst count equal to DEPTH, bit 7 status-valid.
- R2: A status write with bit 6 (command ready) set, made in idle, enters ready and sets status bit 6. The same write made in ready changes nothing.
- R3: A FIFO register (0x024) write made in ready while the buffer is empty enters receiving and stores its byte. A FIFO write in any other state except receiving is dropped.
- R4: In receiving, status bit 3 (expect) reads 1 while fewer than 6 bytes are held or fewer than the size field, where bytes 2..5 form a 32-bit big-endian value. It reads 0 otherwise and in every other state.
- R5: A status write with bit 5 (go) and bit 6 clear, made in receiving with expect clear, enters executing and pulses exec_req for exactly one cycle. With expect set, the write is ignored.
- R6: In executing, core bytes are written at rsp_idx. A rsp_done with length 1..DEPTH enters done, sets status bit 4 (data available) and exposes that many bytes from index 0. Any other length is dropped and the block stays in executing.
- R7: A FIFO read returns the next held byte with count 1 and advances. With nothing left it returns 0 with count 0. The read that takes the last byte clears status bits 4 and 6.
- R8: A command-ready write made in receiving, executing or done returns to idle, empties the buffer and clears status bits 4 and 6.
- R9: An access write with bit 1 set marks the locality active (access bit 5). An access write with bit 5 set clears it and forces idle, and idle always empties the buffer.
- R10: A FIFO write in receiving while DEPTH bytes are already held is discarded, empties the buffer and returns to ready.
- R11: Reads of unmapped addresses return 0 with count 0. Writes to unmapped addresses change nothing.
- R12: Access and status writes act only on data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host register write strobe |
| hw_addr | input | ADDR_W | Host write address |
| hw_data | input | 32 | Host write data (FIFO uses bits 7:0) |
| hr_en | input | 1 | Host register read strobe |
| hr_addr | input | ADDR_W | Host read address |
| hr_data | output | 32 | Read data, valid the cycle after hr_en |
| hr_cnt | output | 3 | Bytes returned by that read |
| exec_req | output | 1 | One-cycle request to run the held command |
| rsp_we | input | 1 | Core response byte write strobe |
| rsp_idx | input | AW | Buffer index for the core byte |
| rsp_byte | input | 8 | Core response byte |
| rsp_done | input | 1 | Core commits a response |
| rsp_len | input | IDX_W | Committed response length |

## Verification
Several invariants are checked on every cycle by the bound checker. Idle always holds an empty buffer. Data-available never appears outside the done state. An execute request is a single-cycle pulse that comes only out of receiving. The fill index never passes DEPTH. The bench's behavioural model, compared every clock, covers what only sequences can show: the size-field expect logic across a streamed header, overflow recovery, rejected response lengths, the drain that clears both flags, and the aborts through command-ready and locality release.

// File: rtl/tpmf_pkg.sv
package tpmf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_DONE
  } tpmf_state_e;

  // status register bit positions
  localparam int STS_VALID_B = 7;
  localparam int CMD_RDY_B   = 6;
  localparam int GO_B        = 5;
  localparam int AVAIL_B     = 4;
  localparam int EXPECT_B    = 3;
  // access register bit positions
  localparam int ACC_VALID_B  = 7;
  localparam int ACC_ACTIVE_B = 5;
  localparam int ACC_REQ_B    = 1;
  // command header: size field occupies bytes 2..5
  localparam int HDR_BYTES  = 6;
  localparam int SIZE_FIRST = 2;
  localparam int SIZE_LAST  = 5;
endpackage

// File: rtl/tpmf_buf.sv
module tpmf_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tpmf_ctrl.sv
module tpmf_ctrl
  import tpmf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int IDX_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_we,
  input  logic             sts_we,
  input  logic             fifo_we,
  input  logic [7:0]       wbyte,
  input  logic             fifo_re,
  input  logic             rsp_we,
  input  logic [AW-1:0]    rsp_idx,
  input  logic [7:0]       rsp_byte,
  input  logic             rsp_done,
  input  logic [IDX_W-1:0] rsp_len,
  output tpmf_state_e      state_o,
  output logic [IDX_W-1:0] ridx_o,
  output logic [IDX_W-1:0] widx_o,
  output logic             cr_o,
  output logic             da_o,
  output logic             act_o,
  output logic             expect_o,
  output logic             exec_o,
  output logic             rd_hit,
  output logic             buf_we,
  output logic [AW-1:0]    buf_waddr,
  output logic [7:0]       buf_wdata,
  output logic [AW-1:0]    buf_raddr
);
  localparam logic [IDX_W-1:0] FULL_L = IDX_W'(DEPTH);

  tpmf_state_e      state_q;
  logic [IDX_W-1:0] ridx_q, widx_q;
  logic             cr_q, da_q, act_q, exec_q;
  logic [31:0]      size_q;

  logic eff_recv, host_acc, host_ovf, host_put, core_put, rsp_ok, to_idle, size_byte;

  assign expect_o  = (state_q == ST_RECV) &&
                     ((widx_q < IDX_W'(HDR_BYTES)) || (32'(widx_q) < size_q));
  assign eff_recv  = (state_q == ST_RECV) || ((state_q == ST_READY) && (widx_q == '0));
  assign host_acc  = fifo_we && eff_recv;
  assign host_ovf  = host_acc && (widx_q == FULL_L);
  assign host_put  = host_acc && !host_ovf;
  assign core_put  = rsp_we && (state_q == ST_EXEC);
  assign rsp_ok    = rsp_done && (state_q == ST_EXEC) &&
                     (rsp_len != '0) && (rsp_len <= FULL_L);
  assign rd_hit    = fifo_re && (widx_q > ridx_q);
  assign size_byte = (widx_q >= IDX_W'(SIZE_FIRST)) && (widx_q <= IDX_W'(SIZE_LAST));
  assign to_idle   = (acc_we && wbyte[ACC_ACTIVE_B]) ||
                     (sts_we && wbyte[CMD_RDY_B] &&
                      (state_q != ST_IDLE) && (state_q != ST_READY));

  assign buf_we    = host_put || core_put;
  assign buf_waddr = host_put ? widx_q[AW-1:0] : rsp_idx;
  assign buf_wdata = host_put ? wbyte : rsp_byte;
  assign buf_raddr = ridx_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ridx_q  <= '0;
      widx_q  <= '0;
      cr_q    <= 1'b0;
      da_q    <= 1'b0;
      act_q   <= 1'b0;
      exec_q  <= 1'b0;
      size_q  <= '0;
    end else begin
      exec_q <= 1'b0;
      // host drain
      if (rd_hit) begin
        ridx_q <= ridx_q + 1'b1;
        if (ridx_q + 1'b1 == widx_q) begin
          da_q <= 1'b0;
          cr_q <= 1'b0;
        end
      end
      // core commits a response
      if (rsp_ok) begin
        ridx_q  <= '0;
        widx_q  <= rsp_len;
        da_q    <= 1'b1;
        state_q <= ST_DONE;
      end
      // command bytes from the host
      if (host_ovf) begin
        widx_q  <= '0;
        state_q <= ST_READY;
      end else if (host_put) begin
        widx_q  <= widx_q + 1'b1;
        state_q <= ST_RECV;
        if (size_byte) size_q <= {size_q[23:0], wbyte};
      end
      // status register control bits
      if (sts_we) begin
        if (wbyte[CMD_RDY_B]) begin
          if (state_q == ST_IDLE) begin
            state_q <= ST_READY;
            cr_q    <= 1'b1;
          end
        end else if (wbyte[GO_B] && (state_q == ST_RECV) && !expect_o) begin
          state_q <= ST_EXEC;
          exec_q  <= 1'b1;
        end
      end
      // locality
      if (acc_we) begin
        if (wbyte[ACC_ACTIVE_B])   act_q <= 1'b0;
        else if (wbyte[ACC_REQ_B]) act_q <= 1'b1;
      end
      // any entry into idle empties the buffer
      if (to_idle) begin
        state_q <= ST_IDLE;
        ridx_q  <= '0;
        widx_q  <= '0;
        cr_q    <= 1'b0;
        da_q    <= 1'b0;
      end
    end
  end

  assign state_o = state_q;
  assign ridx_o  = ridx_q;
  assign widx_o  = widx_q;
  assign cr_o    = cr_q;
  assign da_o    = da_q;
  assign act_o   = act_q;
  assign exec_o  = exec_q;
endmodule

// File: rtl/tpm_fifo_ctrl.sv
module tpm_fifo_ctrl
  import tpmf_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] IDENT    = 32'hC0DE_5EED,
  parameter logic [11:0] OFS_ACC  = 12'h000,
  parameter logic [11:0] OFS_STS  = 12'h018,
  parameter logic [11:0] OFS_FIFO = 12'h024,
  parameter logic [11:0] OFS_ID   = 12'hF00,
  localparam int         AW       = $clog2(DEPTH),
  localparam int         IDX_W    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_en,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [31:0]       hw_data,
  input  logic              hr_en,
  input  logic [ADDR_W-1:0] hr_addr,
  output logic [31:0]       hr_data,
  output logic [2:0]        hr_cnt,
  output logic              exec_req,
  input  logic              rsp_we,
  input  logic [AW-1:0]     rsp_idx,
  input  logic [7:0]        rsp_byte,
  input  logic              rsp_done,
  input  logic [IDX_W-1:0]  rsp_len
);
  localparam logic [1:0]  FAMILY = 2'b01;
  localparam logic [15:0] BURST  = 16'(DEPTH);

  tpmf_state_e      state_w;
  logic [IDX_W-1:0] ridx_w, widx_w;
  logic             cr_w, da_w, act_w, expect_w, rd_hit;
  logic             buf_we;
  logic [AW-1:0]    buf_waddr, buf_raddr;
  logic [7:0]       buf_wdata, buf_rdata;
  logic             acc_we, sts_we, fifo_we, fifo_re;
  logic [31:0]      sts_val, acc_val, reg_q;
  logic             fifo_sel_q;

  assign acc_we  = hw_en && (hw_addr == ADDR_W'(OFS_ACC));
  assign sts_we  = hw_en && (hw_addr == ADDR_W'(OFS_STS));
  assign fifo_we = hw_en && (hw_addr == ADDR_W'(OFS_FIFO));
  assign fifo_re = hr_en && (hr_addr == ADDR_W'(OFS_FIFO));

  tpmf_ctrl #(.DEPTH(DEPTH), .AW(AW), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .acc_we(acc_we), .sts_we(sts_we), .fifo_we(fifo_we), .wbyte(hw_data[7:0]),
    .fifo_re(fifo_re),
    .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte),
    .rsp_done(rsp_done), .rsp_len(rsp_len),
    .state_o(state_w), .ridx_o(ridx_w), .widx_o(widx_w),
    .cr_o(cr_w), .da_o(da_w), .act_o(act_w), .expect_o(expect_w),
    .exec_o(exec_req), .rd_hit(rd_hit),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr)
  );

  tpmf_buf #(.DEPTH(DEPTH), .AW(AW)) buf_i (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .re(rd_hit), .raddr(buf_raddr), .rdata(buf_rdata)
  );

  always_comb begin
    sts_val = '0;
    sts_val[27:26]       = FAMILY;
    sts_val[23:8]        = BURST;
    sts_val[STS_VALID_B] = 1'b1;
    sts_val[CMD_RDY_B]   = cr_w;
    sts_val[AVAIL_B]     = da_w;
    sts_val[EXPECT_B]    = expect_w;
    acc_val = '0;
    acc_val[ACC_VALID_B]  = 1'b1;
    acc_val[ACC_ACTIVE_B] = act_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      hr_cnt     <= '0;
      fifo_sel_q <= 1'b0;
    end else begin
      reg_q      <= '0;
      hr_cnt     <= '0;
      fifo_sel_q <= 1'b0;
      if (hr_en) begin
        if (hr_addr == ADDR_W'(OFS_ID)) begin
          reg_q  <= IDENT;
          hr_cnt <= 3'd4;
        end else if (hr_addr == ADDR_W'(OFS_ACC)) begin
          reg_q  <= acc_val;
          hr_cnt <= 3'd1;
        end else if (hr_addr == ADDR_W'(OFS_STS)) begin
          reg_q  <= sts_val;
          hr_cnt <= 3'd4;
        end else if (fifo_re) begin
          fifo_sel_q <= rd_hit;
          hr_cnt     <= rd_hit ? 3'd1 : 3'd0;
        end
      end
    end
  end

  assign hr_data = fifo_sel_q ? {24'h0, buf_rdata} : reg_q;
endmodule

// File: rtl/tpmf_chk.sv
module tpmf_chk
  import tpmf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input tpmf_state_e      state,
  input logic [IDX_W-1:0] ridx,
  input logic [IDX_W-1:0] widx,
  input logic             da,
  input logic             exec,
  input logic [2:0]       hr_cnt
);
  // R8
  idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (ridx == '0 && widx == '0));
  // R6
  avail_in_done_chk: assert property (@(posedge clk) disable iff (rst)
    da |-> (state == ST_DONE));
  // R5
  exec_entry_chk: assert property (@(posedge clk) disable iff (rst)
    exec |-> (state == ST_EXEC && $past(state) == ST_RECV));
  // R5
  exec_single_chk: assert property (@(posedge clk) disable iff (rst)
    exec |=> !exec);
  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    widx <= IDX_W'(DEPTH));
  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    hr_cnt <= 3'd4);
endmodule

bind tpm_fifo_ctrl tpmf_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .state(state_w), .ridx(ridx_w), .widx(widx_w),
  .da(da_w), .exec(exec_req), .hr_cnt(hr_cnt)
);

// File: tb/tpm_fifo_ctrl_tb.sv
module tpm_fifo_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int IDX_W = 7;
  localparam logic [11:0] A_ACC = 12'h000, A_STS = 12'h018, A_FIFO = 12'h024, A_ID = 12'hF00;
  localparam logic [31:0] ID_VAL = 32'hC0DE_5EED;
  localparam logic [31:0] STS0 = 32'h0400_4080;
  localparam int MI = 0, MR = 1, MV = 2, MX = 3, MD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic hw_en = 0, hr_en = 0, rsp_we = 0, rsp_done = 0;
  logic [11:0] hw_addr = '0, hr_addr = '0;
  logic [31:0] hw_data = '0;
  logic [AW-1:0] rsp_idx = '0;
  logic [7:0] rsp_byte = '0;
  logic [IDX_W-1:0] rsp_len = '0;
  logic [31:0] hr_data;
  logic [2:0] hr_cnt;
  logic exec_req;

  int errs = 0, checks = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tpm_fifo_ctrl dut_i (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
    .hr_en(hr_en), .hr_addr(hr_addr), .hr_data(hr_data), .hr_cnt(hr_cnt),
    .exec_req(exec_req), .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_byte(rsp_byte),
    .rsp_done(rsp_done), .rsp_len(rsp_len)
  );

  // behavioural reference model
  int m_st, m_r, m_w;
  bit m_cr, m_da, m_act, m_live, e_exec;
  byte unsigned m_mem[DEPTH];
  logic [31:0] e_data;
  int e_cnt;

  function automatic bit m_expect();
    longint sz;
    sz = {m_mem[2], m_mem[3], m_mem[4], m_mem[5]};
    return (m_st == MV) && ((m_w < 6) || (m_w < sz));
  endfunction

  function automatic logic [31:0] m_sts();
    return STS0 | (m_cr ? 32'h40 : 0) | (m_da ? 32'h10 : 0) | (m_expect() ? 32'h8 : 0);
  endfunction

  task automatic m_idle();
    m_st = MI; m_r = 0; m_w = 0; m_cr = 0; m_da = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_idle(); m_act = 0; m_live = 0; e_exec = 0; e_data = 0; e_cnt = 0;
    end else begin
      logic [7:0] b;
      m_live = 1; e_exec = 0; e_data = 0; e_cnt = 0;
      if (hr_en) begin
        if (hr_addr == A_ID) begin e_data = ID_VAL; e_cnt = 4; end
        else if (hr_addr == A_ACC) begin e_data = 32'h80 | (m_act ? 32'h20 : 0); e_cnt = 1; end
        else if (hr_addr == A_STS) begin e_data = m_sts(); e_cnt = 4; end
        else if (hr_addr == A_FIFO && m_w > m_r) begin
          e_data = {24'h0, m_mem[m_r]}; e_cnt = 1; m_r++;
          if (m_r == m_w) begin m_da = 0; m_cr = 0; end
        end
      end
      if (m_st == MX) begin
        if (rsp_we) m_mem[rsp_idx] = rsp_byte;
        if (rsp_done && rsp_len >= 1 && rsp_len <= DEPTH) begin
          m_r = 0; m_w = int'(rsp_len); m_da = 1; m_st = MD;
        end
      end
      if (hw_en) begin
        b = hw_data[7:0];
        if (hw_addr == A_ACC) begin
          if (b[5]) begin m_act = 0; m_idle(); end
          else if (b[1]) m_act = 1;
        end else if (hw_addr == A_STS) begin
          if (b[6]) begin
            if (m_st == MI) begin m_st = MR; m_cr = 1; end
            else if (m_st != MR) m_idle();
          end else if (b[5] && m_st == MV && !m_expect()) begin
            m_st = MX; e_exec = 1;
          end
        end else if (hw_addr == A_FIFO) begin
          if (m_st == MR && m_w == 0) m_st = MV;
          if (m_st == MV) begin
            if (m_w == DEPTH) begin m_w = 0; m_st = MR; end
            else begin m_mem[m_w] = b; m_w++; end
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live && !rst && !finished) begin
      chk({cur_req, " model data"}, hr_data, e_data);
      chk({cur_req, " model count"}, {29'h0, hr_cnt}, e_cnt);
      chk({cur_req, " model exec"}, {31'h0, exec_req}, {31'h0, e_exec});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    hw_en = 1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] ed, input int ec, input string tag);
    hr_en = 1; hr_addr = a;
    @(negedge clk);
    hr_en = 0;
    chk(tag, hr_data, ed);
    chk(tag, {29'h0, hr_cnt}, ec);
  endtask

  task automatic core_put(input int idx, input logic [7:0] v);
    rsp_we = 1; rsp_idx = AW'(idx); rsp_byte = v;
    @(negedge clk);
    rsp_we = 0;
  endtask

  task automatic core_done(input int len);
    rsp_done = 1; rsp_len = IDX_W'(len);
    @(negedge clk);
    rsp_done = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] cmd10 [10];
    cmd10 = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h01, 8'h44};
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset values
    cur_req = "R1";
    rd_exp(A_ID, ID_VAL, 4, "R1 ident");
    rd_exp(A_ACC, 32'h80, 1, "R1 access");
    rd_exp(A_STS, STS0, 4, "R1 status");

    // R11: unmapped read and write
    cur_req = "R11";
    rd_exp(12'h004, 32'h0, 0, "R11 unmapped read");
    wr(12'h01C, 32'h40);
    rd_exp(A_STS, STS0, 4, "R11 unmapped write ignored");

    // R3: FIFO write in idle dropped
    cur_req = "R3";
    wr(A_FIFO, 32'h5A);
    rd_exp(A_FIFO, 32'h0, 0, "R3 idle write dropped");

    // R9: request locality
    cur_req = "R9";
    wr(A_ACC, 32'h02);
    rd_exp(A_ACC, 32'hA0, 1, "R9 locality active");

    // R12: only low byte used
    cur_req = "R12";
    wr(A_STS, 32'hFFFF_FF00);
    rd_exp(A_STS, STS0, 4, "R12 status upper bytes ignored");
    wr(A_ACC, 32'hFFFF_FF00);
    rd_exp(A_ACC, 32'hA0, 1, "R12 access upper bytes ignored");

    // R2: command ready from idle, then repeat in ready
    cur_req = "R2";
    wr(A_STS, 32'h40);
    rd_exp(A_STS, STS0 | 32'h40, 4, "R2 ready");
    wr(A_STS, 32'h40);
    rd_exp(A_STS, STS0 | 32'h40, 4, "R2 ready repeat");

    // R4 / R5: stream a 10-byte command
    cur_req = "R4";
    wr(A_FIFO, {24'h0, cmd10[0]});
    rd_exp(A_STS, STS0 | 32'h48, 4, "R4 expect after first byte");
    cur_req = "R5";
    wr(A_STS, 32'h20);
    chk("R5 go with expect set ignored", {31'h0, exec_req}, 32'h0);
    cur_req = "R4";
    for (int i = 1; i < 10; i++) wr(A_FIFO, {24'h0, cmd10[i]});
    rd_exp(A_STS, STS0 | 32'h40, 4, "R4 expect cleared at size");
    cur_req = "R5";
    wr(A_STS, 32'h20);
    chk("R5 exec pulse", {31'h0, exec_req}, 32'h1);
    @(negedge clk);
    chk("R5 exec single cycle", {31'h0, exec_req}, 32'h0);

    // R6: bad length, then echo response
    cur_req = "R6";
    core_done(0);
    rd_exp(A_STS, STS0 | 32'h40, 4, "R6 zero length dropped");
    core_put(0, 8'hC4); core_put(1, 8'h01); core_put(2, 8'h02); core_put(3, 8'h03);
    core_done(4);
    rd_exp(A_STS, STS0 | 32'h50, 4, "R6 data available");

    // R7: drain
    cur_req = "R7";
    rd_exp(A_FIFO, 32'hC4, 1, "R7 byte 0");
    rd_exp(A_FIFO, 32'h01, 1, "R7 byte 1");
    rd_exp(A_FIFO, 32'h02, 1, "R7 byte 2");
    rd_exp(A_FIFO, 32'h03, 1, "R7 byte 3");
    rd_exp(A_STS, STS0, 4, "R7 flags cleared on drain");
    rd_exp(A_FIFO, 32'h0, 0, "R7 empty read");

    // R8: abort with bytes still pending
    cur_req = "R8";
    wr(A_STS, 32'h40);
    wr(A_STS, 32'h40);
    rd_exp(A_STS, STS0 | 32'h40, 4, "R8 back to ready");
    wr(A_FIFO, 32'h80); wr(A_FIFO, 32'h01); wr(A_FIFO, 32'h00);
    wr(A_FIFO, 32'h00); wr(A_FIFO, 32'h00); wr(A_FIFO, 32'h06);
    wr(A_STS, 32'h20);
    cur_req = "R6";
    core_done(65);
    rd_exp(A_STS, STS0 | 32'h40, 4, "R6 oversize dropped");
    core_put(0, 8'hAA); core_put(1, 8'hBB);
    core_done(2);
    rd_exp(A_FIFO, 32'hAA, 1, "R6 first byte");
    cur_req = "R8";
    wr(A_STS, 32'h40);
    rd_exp(A_STS, STS0, 4, "R8 idle flags cleared");
    rd_exp(A_FIFO, 32'h0, 0, "R8 buffer emptied");

    // R10: overflow
    cur_req = "R10";
    wr(A_STS, 32'h40);
    wr(A_FIFO, 32'h80); wr(A_FIFO, 32'h01); wr(A_FIFO, 32'h00);
    wr(A_FIFO, 32'h00); wr(A_FIFO, 32'h01); wr(A_FIFO, 32'h00);
    for (int i = 6; i < DEPTH; i++) wr(A_FIFO, 32'(i));
    rd_exp(A_STS, STS0 | 32'h48, 4, "R10 full still expecting");
    wr(A_FIFO, 32'h77);
    rd_exp(A_STS, STS0 | 32'h40, 4, "R10 back to ready");
    rd_exp(A_FIFO, 32'h0, 0, "R10 buffer emptied");

    // R9: relinquish forces idle
    cur_req = "R9";
    wr(A_FIFO, 32'h80);
    wr(A_ACC, 32'h20);
    rd_exp(A_ACC, 32'h80, 1, "R9 locality released");
    rd_exp(A_STS, STS0, 4, "R9 forced idle");
    rd_exp(A_FIFO, 32'h0, 0, "R9 buffer emptied");

    @(negedge clk);
    summary();
  end
endmodule